// File: doc/BRIEF.md
# Stereo One-Bit Bitstream Decimator

This block turns two one-bit sigma-delta bitstreams, one for the left channel and one for the right, into 16-bit twos-complement audio words. Each stream carries 64 bits per output sample period. The input stage for each channel is a third-order integrator-comb filter that runs on every accepted bit and is read out once per 64 bits. A four-tap symmetric, linear-phase FIR follows it at the output rate. The final stage rounds the FIR sum to 16 bits and clips it to full scale.

The comb, FIR, rounding and clipping logic is built once. The two channels use it one after the other in the two clock cycles that follow each frame boundary. Both words then appear together, marked by a single one-cycle valid strobe. The upstream modulator presents one bit per channel and raises `bit_en` whenever that bit should be taken. The clock may run at the bit rate or faster.

Top module: `bsd_stereo_decimator`

## Requirements
- R1: A bit is accepted on a rising edge where `bit_en` is 1. Input bit value 1 counts as +1 and bit value 0 counts as -1. Every 64 accepted bits form one frame, and each frame produces one output pair.
- R2: A bit pattern that repeats every 64 bits and holds k ones per frame settles, after six frames, to the word 1024*(k-32), clipped as in R5.
- R3: Each channel is filtered by a third-order integrator-comb decimator with differential delay 1, read at the 64th bit of each frame. Its output y feeds a four-tap FIR with taps {-2, 10, 10, -2}, applied newest sample first. The FIR sum is scaled down by 2^7.
- R4: The scaled result is rounded half-up: 64 is added to the FIR sum before an arithmetic right shift by 7.
- R5: A rounded value above 32767 gives 32767 (16'h7FFF). A rounded value below -32768 gives -32768 (16'h8000). The output never wraps.
- R6: `out_valid` is a one-cycle pulse. It is high in the cycle that follows the second rising edge after the edge that accepts a frame's 64th bit. Both words change together for that pulse and hold their values until the next one.
- R7: After reset, `out_valid` stays low for the first five frames and pulses first for the sixth frame. From then on it pulses for every frame.
- R8: While `rst_n` is low on a rising edge, all filter state and both output words are cleared to 0, and `out_valid` is 0.
- R9: The left word depends only on `left_bit`, and the right word depends only on `right_bit`, even though the two channels share one arithmetic path.
- R10: A cycle with `bit_en` low leaves the filter state and the outputs unchanged, whatever the bit inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Accept the current bit of both channels |
| left_bit | input | 1 | Left-channel one-bit stream |
| right_bit | input | 1 | Right-channel one-bit stream |
| out_valid | output | 1 | One-cycle strobe marking a new output pair |
| left_word | output | 16 | Left twos-complement sample |
| right_word | output | 16 | Right twos-complement sample |

## Verification
The embedded assertions check, on every cycle:
- the integrator state holds when no bit is accepted;
- the left and right passes run in order;
- the valid strobe lasts one cycle and only follows a right-channel pass after the pipeline has filled;
- the right-channel snapshot stays stable while it waits.

Only the bench scenarios can show the arithmetic itself. The bench compares every output pair against an independent convolution model of the filter chain. This covers steady DC levels, step transients that overshoot into clipping, rounding of odd sums, channel separation, the six-frame fill after a mid-frame reset, and toggled bits that are ignored.

// File: rtl/bsd_pkg.sv
// Shared constants for the stereo bitstream decimator.
// Assumes a power-of-two decimation factor and a tap set whose sum is a power of two.
package bsd_pkg;
    localparam int NCH          = 2;
    localparam int DECIM        = 64;
    localparam int CIC_ORDER    = 3;
    localparam int OUT_W        = 16;
    localparam int NTAPS        = 4;
    localparam int NHALF        = NTAPS / 2;
    localparam int COEF_W       = 6;
    localparam int COEF_SUM_LG2 = 4;
    localparam int CIC_GROW     = CIC_ORDER * $clog2(DECIM);
    localparam int CIC_W        = CIC_GROW + 2;
    localparam int ACC_W        = CIC_W + 1 + COEF_W + $clog2(NHALF) + 1;
    localparam int SHIFT        = CIC_GROW + COEF_SUM_LG2 - (OUT_W - 1);
    localparam int FILL         = CIC_ORDER + NTAPS - 1;

    // One half of the symmetric tap set; index k pairs with NTAPS-1-k.
    function automatic logic signed [COEF_W-1:0] half_coef(input int k);
        case (k)
            0:       return COEF_W'(-2);
            1:       return COEF_W'(10);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/bsd_integrator.sv
// Cascade of integrators for one channel, updated once per accepted bit.
// Assumes the register width covers the full filter growth, so wraparound is harmless.
// acc_next is the value the last stage takes on the current edge.
module bsd_integrator #(
    parameter int ORDER = bsd_pkg::CIC_ORDER,
    parameter int W     = bsd_pkg::CIC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic signed [W-1:0] acc_next
);
    logic signed [W-1:0] st [ORDER];
    logic signed [W-1:0] nx [ORDER];
    logic signed [W-1:0] step;

    // Map the input bit to +1 or -1 and ripple it through the stages.
    always_comb begin
        logic signed [W-1:0] run;
        step = {{(W-1){~bit_in}}, 1'b1};
        run  = step;
        for (int s = 0; s < ORDER; s++) begin
            run   = st[s] + run;
            nx[s] = run;
        end
        acc_next = nx[ORDER-1];
    end

    // Integrator registers advance only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < ORDER; s++) st[s] <= '0;
        end else if (bit_en) begin
            for (int s = 0; s < ORDER; s++) st[s] <= nx[s];
        end
    end

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st[ORDER-1]));
endmodule

// File: rtl/bsd_comb_fir.sv
// Shared comb and symmetric FIR datapath, used by one channel per enabled cycle.
// Holds comb delays and FIR delay lines per channel, and updates only the selected channel.
// Pre-adds mirrored taps so that each tap pair needs one multiply; acc is the FIR sum.
module bsd_comb_fir #(
    parameter int NCH    = bsd_pkg::NCH,
    parameter int ORDER  = bsd_pkg::CIC_ORDER,
    parameter int NTAPS  = bsd_pkg::NTAPS,
    parameter int W      = bsd_pkg::CIC_W,
    parameter int ACC_W  = bsd_pkg::ACC_W,
    parameter int COEF_W = bsd_pkg::COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [$clog2(NCH)-1:0]   ch,
    input  logic signed [W-1:0]      sample,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int NHALF = NTAPS / 2;

    logic signed [W-1:0] dly  [NCH][ORDER];
    logic signed [W-1:0] line [NCH][NTAPS];
    logic signed [W-1:0] cin  [ORDER];
    logic signed [W-1:0] nl   [NTAPS];

    // Comb chain, delay-line shift and pre-added multiply-accumulate for the selected channel.
    always_comb begin
        logic signed [W-1:0]      run;
        logic signed [W:0]        pre;
        logic signed [ACC_W-1:0]  pw;
        logic signed [ACC_W-1:0]  cw;
        run = sample;
        for (int s = 0; s < ORDER; s++) begin
            cin[s] = run;
            run    = run - dly[ch][s];
        end
        nl[0] = run;
        for (int k = 1; k < NTAPS; k++) nl[k] = line[ch][k-1];
        acc = '0;
        for (int k = 0; k < NHALF; k++) begin
            pre = {nl[k][W-1], nl[k]} + {nl[NTAPS-1-k][W-1], nl[NTAPS-1-k]};
            pw  = ACC_W'(pre);
            cw  = ACC_W'(bsd_pkg::half_coef(k));
            acc = acc + pw * cw;
        end
    end

    // Commit the comb delays and delay line of the channel just processed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int s = 0; s < ORDER; s++) dly[c][s] <= '0;
                for (int k = 0; k < NTAPS; k++) line[c][k] <= '0;
            end
        end else if (en) begin
            for (int s = 0; s < ORDER; s++) dly[ch][s] <= cin[s];
            for (int k = 0; k < NTAPS; k++) line[ch][k] <= nl[k];
        end
    end

    assert_left_before_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ch != '0) |-> $past(en && ch == '0));
endmodule

// File: rtl/bsd_round_sat.sv
// Round-half-up scaling of the FIR sum, followed by clipping to the output width.
// Purely combinational; assumes ACC_W is wide enough that the added half cannot overflow.
module bsd_round_sat #(
    parameter int ACC_W = bsd_pkg::ACC_W,
    parameter int OUT_W = bsd_pkg::OUT_W,
    parameter int SHIFT = bsd_pkg::SHIFT
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        word
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(2 ** (OUT_W - 1)));

    logic signed [ACC_W-1:0] scaled;

    // Add half an output step, shift, then clip to full scale.
    always_comb begin
        scaled = (acc + HALF) >>> SHIFT;
        if (scaled > MAXV)      word = MAXV[OUT_W-1:0];
        else if (scaled < MINV) word = MINV[OUT_W-1:0];
        else                    word = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/bsd_stereo_decimator.sv
// Stereo one-bit to 16-bit decimator (factor DECIM).
// Per-channel integrators run on every accepted bit. At each frame end their values are
// captured, then passed left and right through one shared comb/FIR/round path.
// Assumes DECIM >= 3, so the two-cycle shared pass ends before the next frame ends.
module bsd_stereo_decimator #(
    parameter int DECIM = bsd_pkg::DECIM,
    parameter int OUT_W = bsd_pkg::OUT_W,
    parameter int CIC_W = bsd_pkg::CIC_W,
    parameter int ACC_W = bsd_pkg::ACC_W,
    parameter int FILL  = bsd_pkg::FILL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             left_bit,
    input  logic             right_bit,
    output logic             out_valid,
    output logic [OUT_W-1:0] left_word,
    output logic [OUT_W-1:0] right_word
);
    localparam int NCH  = bsd_pkg::NCH;
    localparam int CNTW = $clog2(DECIM);
    localparam int FW   = $clog2(FILL + 1);

    logic [CNTW-1:0]          bit_cnt;
    logic [FW-1:0]            frame_cnt;
    logic                     frame_end;
    logic                     proc_en;
    logic                     proc_ch;
    logic [NCH-1:0]           bits;
    logic signed [CIC_W-1:0]  acc_nx [NCH];
    logic signed [CIC_W-1:0]  snap   [NCH];
    logic signed [ACC_W-1:0]  fir_acc;
    logic [OUT_W-1:0]         word;

    assign bits      = {right_bit, left_bit};
    assign frame_end = bit_en && (bit_cnt == CNTW'(DECIM - 1));

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        bsd_integrator u_int (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_en   (bit_en),
            .bit_in   (bits[g]),
            .acc_next (acc_nx[g])
        );

        // Capture this channel's integrator output on the frame's last bit.
        always_ff @(posedge clk) begin
            if (!rst_n)         snap[g] <= '0;
            else if (frame_end) snap[g] <= acc_nx[g];
        end
    end

    // Count bits within a frame and frames up to the fill point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            frame_cnt <= '0;
        end else if (bit_en) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (frame_end && frame_cnt < FW'(FILL)) frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // Sequence the shared pass: left channel first, then right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_en <= 1'b0;
            proc_ch <= 1'b0;
        end else if (frame_end) begin
            proc_en <= 1'b1;
            proc_ch <= 1'b0;
        end else if (proc_en && !proc_ch) begin
            proc_ch <= 1'b1;
        end else begin
            proc_en <= 1'b0;
        end
    end

    bsd_comb_fir u_fir (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (proc_en),
        .ch     (proc_ch),
        .sample (snap[proc_ch]),
        .acc    (fir_acc)
    );

    bsd_round_sat u_rs (
        .acc  (fir_acc),
        .word (word)
    );

    // Register the words and raise the strobe once the pipeline has filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
            out_valid  <= 1'b0;
        end else begin
            if (proc_en && !proc_ch) left_word  <= word;
            if (proc_en &&  proc_ch) right_word <= word;
            out_valid <= proc_en && proc_ch && (frame_cnt >= FW'(FILL));
        end
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_valid_after_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(proc_en && proc_ch));
    assert_filled_before_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (frame_cnt >= FW'(FILL)));
    assert_right_snap_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_en && proc_ch) |-> $stable(snap[1]));
endmodule

// File: tb/bsd_stereo_decimator_bench.sv
// Bench: a table of steady patterns with expected settled words, checks of every
// output pair against a convolution model, then directed reset, fill and idle tests.
module bsd_stereo_decimator_bench;
    localparam int PERIOD = 10;
    localparam int NENT   = 5;
    localparam int KLEN   = 190;

    localparam logic [63:0] PAT_L [NENT] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_0000,
        64'h00FF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0 };
    localparam logic [63:0] PAT_R [NENT] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FFFF,
        64'h0000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_FFFE };
    localparam int EXP_L [NENT] = '{ 32767, 0, 16384, 24576, 0 };
    localparam int EXP_R [NENT] = '{ -32768, 32767, -16384, -28672, 31744 };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic left_bit = 1'b0;
    logic right_bit = 1'b0;
    logic out_valid;
    logic [15:0] left_word;
    logic [15:0] right_word;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int fend_cyc = 0;
    int bitnum = 0;
    int vcount = 0;
    int kern [KLEN];
    bit hist_l [8192];
    bit hist_r [8192];

    bsd_stereo_decimator u_bsd_stereo_decimator (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .left_bit(left_bit),
        .right_bit(right_bit), .out_valid(out_valid), .left_word(left_word),
        .right_word(right_word)
    );

    always #(PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Integrator-comb output for frame m: triple box kernel over the bit history.
    function automatic longint cic_y(input bit right, input int m);
        longint s = 0;
        if (m < 1) return 0;
        for (int j = 0; j < KLEN; j++) begin
            int idx = 64 * m - 1 - j;
            if (idx >= 0) begin
                bit b = right ? hist_r[idx] : hist_l[idx];
                s += longint'(kern[j]) * (b ? 1 : -1);
            end
        end
        return s;
    endfunction

    // Taps {-2,10,10,-2}, add 64, shift by 7, clip to 16 bits.
    function automatic int exp_word(input bit right, input int m);
        longint a;
        longint r;
        a = -2 * cic_y(right, m) + 10 * cic_y(right, m - 1)
            + 10 * cic_y(right, m - 2) - 2 * cic_y(right, m - 3);
        r = (a + 64) >>> 7;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Monitor: each valid pair must match the model and arrive two edges after the frame end.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int m;
            vcount++;
            m = 5 + vcount;
            chk("R1 R6 valid timing", cyc, fend_cyc + 2);
            chk("R3 R4 R5 left word", int'($signed(left_word)), exp_word(1'b0, m));
            chk("R3 R4 R5 right word", int'($signed(right_word)), exp_word(1'b1, m));
        end
    end

    task automatic send_bit(input bit l, input bit r);
        hist_l[bitnum] = l;
        hist_r[bitnum] = r;
        bitnum++;
        left_bit  = l;
        right_bit = r;
        bit_en    = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (bitnum % 64 == 0) fend_cyc = cyc;
        if (bitnum % 5 == 0) begin
            left_bit  = ~l;
            right_bit = ~r;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [63:0] pl, input logic [63:0] pr);
        for (int i = 0; i < 64; i++) send_bit(pl[i], pr[i]);
    endtask

    initial begin
        for (int j = 0; j < KLEN; j++) kern[j] = 0;
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int c = 0; c < 64; c++) kern[a + b + c]++;

        // R8: reset state.
        repeat (3) @(negedge clk);
        chk("R8 valid in reset", int'(out_valid), 0);
        chk("R8 left in reset", int'(left_word), 0);
        chk("R8 right in reset", int'(right_word), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R9: table of steady patterns, settled words per channel.
        for (int e = 0; e < NENT; e++) begin
            repeat (8) send_frame(PAT_L[e], PAT_R[e]);
            repeat (4) @(negedge clk);
            chk("R2 R9 settled left", int'($signed(left_word)), EXP_L[e]);
            chk("R2 R9 settled right", int'($signed(right_word)), EXP_R[e]);
        end

        // R8: reset in mid-frame.
        for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 valid after reset", int'(out_valid), 0);
        chk("R8 left after reset", int'(left_word), 0);
        chk("R8 right after reset", int'(right_word), 0);
        bitnum = 0;
        vcount = 0;
        rst_n  = 1'b1;
        @(negedge clk);

        // R7: five frames produce no strobe, the sixth produces one.
        repeat (5) send_frame(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        repeat (4) @(negedge clk);
        chk("R7 no valid before fill", vcount, 0);
        send_frame(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        repeat (4) @(negedge clk);
        chk("R7 first valid at sixth frame", vcount, 1);
        chk("R5 positive clip", int'($signed(left_word)), 32767);
        chk("R5 negative clip", int'($signed(right_word)), -32768);

        // R10: toggled bits with bit_en low change nothing.
        for (int i = 0; i < 100; i++) begin
            left_bit  = i[0];
            right_bit = ~i[1];
            @(negedge clk);
        end
        chk("R10 no strobe while idle", vcount, 1);
        chk("R10 left held", int'($signed(left_word)), 32767);
        chk("R10 right held", int'($signed(right_word)), -32768);
        // R10 R5: step down overshoots into negative clipping; the monitor checks every frame.
        repeat (3) send_frame(64'h0, 64'h5555_5555_AAAA_AAAA);
        repeat (4) @(negedge clk);
        chk("R10 frames after idle", vcount, 4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule